// File: doc/BRIEF.md
# Accumulator BCD Adjust and Sign-Extension Unit

This block applies the correction step that follows byte arithmetic on unpacked (ASCII) or packed decimal digits. It also performs the two sign-widening moves of an accumulator-based datapath. Eight operations are provided. Four of them fix up after addition or subtraction: unpacked add, unpacked subtract, packed add and packed subtract. A multi-cycle operation splits a byte into two decimal digits. A single-cycle operation merges two digits back into one byte. The last two copy the sign of the low byte into the high byte, and the sign of the 16-bit accumulator into the extension word. The add or subtract that comes before a correction is done elsewhere. This unit only sees its byte result and its incoming half-carry and carry.

The caller presents the low byte, the high byte, the extension word, the half-carry, the carry and an operation code, and raises `start` for one cycle. Every operation except the digit split returns its registered results with a one-cycle `done` pulse on the edge that accepts it. The digit split runs a bit-serial divide by ten. It raises `busy` until its `done` pulse. Any flag that the operation leaves undefined is driven to 0.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is 0, including `busy` and `done`.
- R2: Op code 0 (unpacked add fix). If `al_in[3:0]` > 9 or `af_in`=1, then `al_out` = (`al_in`+6) & 0x0F, `ah_out` = `ah_in`+1, and `af_out` = `cf_out` = 1. Otherwise `al_out` = `al_in` & 0x0F, `ah_out` = `ah_in`, and `af_out` = `cf_out` = 0. For example, `al_in`=0x66 with `ah_in`=0 gives `al_out`=0x06, `ah_out`=0, and both flags clear.
- R3: Op code 1 (unpacked subtract fix). The condition is the same as R2. When it holds, `al_out` = (`al_in`−6) & 0x0F, `ah_out` = `ah_in`−1, and `af_out` = `cf_out` = 1. Otherwise it behaves exactly like the else case of R2.
- R4: Op code 2 (packed add fix). Add 0x06 when `al_in[3:0]` > 9 or `af_in`=1; `af_out` shows whether this was done. Add 0x60 as well when the original `al_in` > 0x99 or `cf_in`=1; `cf_out` shows whether this was done. Both additions wrap modulo 256. `ah_out` = `ah_in`.
- R5: Op code 3 (packed subtract fix). It mirrors R4, but subtracts 0x06 and 0x60 under the same conditions, with the same flag meaning.
- R6: Op code 4 (digit split). `ah_out` = `al_in`/10 and `al_out` = `al_in` mod 10. `busy` is high from the cycle after acceptance until `done`. The `done` pulse comes no more than 12 cycles after `start`.
- R7: Op code 5 (digit merge). `al_out` = (`ah_in`·10 + `al_in`) mod 256 and `ah_out` = 0.
- R8: Op code 6 (byte widen). `ah_out` has every bit equal to `al_in[7]`. `al_out` = `al_in`.
- R9: Op code 7 (word widen). `dx_out` has every bit equal to `ah_in[7]`. `al_out` and `ah_out` pass through unchanged.
- R10: For every op except 7, `dx_out` = the `dx_in` sampled at acceptance. `start` is ignored while `busy` is high: no extra `done` is produced and the pending result is not disturbed. Outputs change only on a `done` cycle.
- R11: SF, ZF and PF are set from the final `al_out` for ops 2, 3, 4 and 5. PF means an even count of ones. OF is always 0. SF/ZF/PF are 0 for ops 0 and 1. AF/CF are 0 for ops 4 and 5. Ops 6 and 7 pass `af_in`/`cf_in` through and drive the other flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when `busy` is low |
| op | input | 3 | Operation code (R2–R9) |
| al_in | input | 8 | Accumulator low byte |
| ah_in | input | 8 | Accumulator high byte |
| dx_in | input | 16 | Extension word |
| af_in | input | 1 | Incoming half-carry |
| cf_in | input | 1 | Incoming carry |
| busy | output | 1 | Digit split in progress |
| done | output | 1 | One-cycle result-valid pulse |
| al_out | output | 8 | Result low byte |
| ah_out | output | 8 | Result high byte |
| dx_out | output | 16 | Result extension word |
| cf_out | output | 1 | Carry flag |
| pf_out | output | 1 | Parity flag (even) |
| af_out | output | 1 | Half-carry flag |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Sign flag |
| of_out | output | 1 | Overflow flag, always 0 |

## Verification
The properties rely on the caller keeping `op` and the data inputs meaningful only on the cycle `start` is accepted. They also rely on each `done` being tied to the most recent accepted request, which holds only because a `start` raised during `busy` is dropped. The stimulus holds every request for exactly one cycle. It waits for `done` before issuing the next, except in one deliberate case that fires a request into a running digit split to show that it is dropped. The random values cover the full byte and flag ranges. Directed cases hit the nibble and 0x99 boundaries, the 0xFF split and merge wrap, and both signs for widening.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    OP_UADD  = 3'd0,
    OP_USUB  = 3'd1,
    OP_PADD  = 3'd2,
    OP_PSUB  = 3'd3,
    OP_SPLIT = 3'd4,
    OP_MERGE = 3'd5,
    OP_WIDB  = 3'd6,
    OP_WIDW  = 3'd7
  } adj_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic [WORD_W-1:0] ext;
    logic              cf;
    logic              pf;
    logic              af;
    logic              zf;
    logic              sf;
    logic              of;
  } adj_res_t;
endpackage

// File: rtl/bcd_addsub_fix.sv
module bcd_addsub_fix
  import bcd_adj_pkg::*;
(
  input  adj_op_e           op,
  input  logic [BYTE_W-1:0] al,
  input  logic [BYTE_W-1:0] ah,
  input  logic [WORD_W-1:0] dx,
  input  logic              af_i,
  input  logic              cf_i,
  output adj_res_t          res
);
  localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(9);
  localparam logic [NIB_W-1:0]  NIB_FIX  = NIB_W'(6);
  localparam logic [BYTE_W-1:0] LO_FIX   = BYTE_W'(8'h06);
  localparam logic [BYTE_W-1:0] HI_FIX   = BYTE_W'(8'h60);
  localparam logic [BYTE_W-1:0] BYTE_MAX = BYTE_W'(8'h99);

  logic              lo_adj, hi_adj;
  logic [BYTE_W-1:0] pk_add, pk_sub, pk_val;

  assign lo_adj = (al[NIB_W-1:0] > NIB_MAX) || af_i;
  assign hi_adj = (al > BYTE_MAX) || cf_i;
  assign pk_add = al + (lo_adj ? LO_FIX : '0) + (hi_adj ? HI_FIX : '0);
  assign pk_sub = al - (lo_adj ? LO_FIX : '0) - (hi_adj ? HI_FIX : '0);
  assign pk_val = (op == OP_PSUB) ? pk_sub : pk_add;

  always_comb begin
    res     = '0;
    res.lo  = al;
    res.hi  = ah;
    res.ext = dx;
    case (op)
      OP_UADD, OP_USUB: begin
        if (lo_adj) begin
          res.lo[NIB_W-1:0] = (op == OP_UADD) ? (al[NIB_W-1:0] + NIB_FIX)
                                              : (al[NIB_W-1:0] - NIB_FIX);
          res.hi = (op == OP_UADD) ? (ah + 1'b1) : (ah - 1'b1);
          res.af = 1'b1;
          res.cf = 1'b1;
        end
        res.lo[BYTE_W-1:NIB_W] = '0;
      end
      OP_PADD, OP_PSUB: begin
        res.lo = pk_val;
        res.af = lo_adj;
        res.cf = hi_adj;
        res.sf = pk_val[BYTE_W-1];
        res.zf = (pk_val == '0);
        res.pf = ~^pk_val;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_merge_widen.sv
module bcd_merge_widen
  import bcd_adj_pkg::*;
(
  input  adj_op_e           op,
  input  logic [BYTE_W-1:0] al,
  input  logic [BYTE_W-1:0] ah,
  input  logic [WORD_W-1:0] dx,
  input  logic              af_i,
  input  logic              cf_i,
  output adj_res_t          res
);
  logic [BYTE_W-1:0] merged;
  logic [BYTE_W-1:0] fill_b;
  logic [WORD_W-1:0] fill_w;

  // ten times the high digit is eight times plus two times
  assign merged = (ah << 3) + (ah << 1) + al;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_fill_b
    assign fill_b[i] = al[BYTE_W-1];
  end
  for (genvar j = 0; j < WORD_W; j++) begin : g_fill_w
    assign fill_w[j] = ah[BYTE_W-1];
  end

  always_comb begin
    res     = '0;
    res.lo  = al;
    res.hi  = ah;
    res.ext = dx;
    case (op)
      OP_MERGE: begin
        res.lo = merged;
        res.hi = '0;
        res.sf = merged[BYTE_W-1];
        res.zf = (merged == '0);
        res.pf = ~^merged;
      end
      OP_WIDB: begin
        res.hi = fill_b;
        res.af = af_i;
        res.cf = cf_i;
      end
      OP_WIDW: begin
        res.ext = fill_w;
        res.af  = af_i;
        res.cf  = cf_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_div_const.sv
module bcd_div_const #(
  parameter int W       = 8,
  parameter int DIVISOR = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  output logic         valid,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W:0] DIV_V = (W+1)'(DIVISOR);

  logic [CW-1:0] steps;
  logic          active;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {rem, quot[W-1]};
  assign fits  = (trial >= DIV_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      steps  <= '0;
      active <= 1'b0;
      valid  <= 1'b0;
      quot   <= '0;
      rem    <= '0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        quot   <= dividend;
        rem    <= '0;
        steps  <= CW'(W);
        active <= 1'b1;
      end else if (active) begin
        rem   <= fits ? W'(trial - DIV_V) : trial[W-1:0];
        quot  <= {quot[W-2:0], fits};
        steps <= steps - 1'b1;
        if (steps == CW'(1)) begin
          active <= 1'b0;
          valid  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [7:0]  al_in,
  input  logic [7:0]  ah_in,
  input  logic [15:0] dx_in,
  input  logic        af_in,
  input  logic        cf_in,
  output logic        busy,
  output logic        done,
  output logic [7:0]  al_out,
  output logic [7:0]  ah_out,
  output logic [15:0] dx_out,
  output logic        cf_out,
  output logic        pf_out,
  output logic        af_out,
  output logic        zf_out,
  output logic        sf_out,
  output logic        of_out
);
  adj_op_e     op_e;
  logic        accept, div_go, div_valid;
  adj_res_t    res_fix, res_mw, res_sel;
  logic [BYTE_W-1:0] div_q, div_r;
  logic [WORD_W-1:0] dx_keep;

  assign op_e   = adj_op_e'(op);
  assign accept = start && !busy;
  assign div_go = accept && (op_e == OP_SPLIT);

  bcd_addsub_fix u_fix (
    .op(op_e), .al(al_in), .ah(ah_in), .dx(dx_in),
    .af_i(af_in), .cf_i(cf_in), .res(res_fix)
  );

  bcd_merge_widen u_mw (
    .op(op_e), .al(al_in), .ah(ah_in), .dx(dx_in),
    .af_i(af_in), .cf_i(cf_in), .res(res_mw)
  );

  bcd_div_const #(.W(BYTE_W), .DIVISOR(10)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .dividend(al_in),
    .valid(div_valid), .quot(div_q), .rem(div_r)
  );

  assign res_sel = (op_e inside {OP_UADD, OP_USUB, OP_PADD, OP_PSUB}) ? res_fix : res_mw;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      al_out  <= '0;
      ah_out  <= '0;
      dx_out  <= '0;
      dx_keep <= '0;
      cf_out  <= 1'b0;
      pf_out  <= 1'b0;
      af_out  <= 1'b0;
      zf_out  <= 1'b0;
      sf_out  <= 1'b0;
      of_out  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (div_go) begin
        busy    <= 1'b1;
        dx_keep <= dx_in;
      end else if (accept) begin
        done   <= 1'b1;
        al_out <= res_sel.lo;
        ah_out <= res_sel.hi;
        dx_out <= res_sel.ext;
        cf_out <= res_sel.cf;
        pf_out <= res_sel.pf;
        af_out <= res_sel.af;
        zf_out <= res_sel.zf;
        sf_out <= res_sel.sf;
        of_out <= res_sel.of;
      end else if (div_valid) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        al_out <= div_r;
        ah_out <= div_q;
        dx_out <= dx_keep;
        cf_out <= 1'b0;
        af_out <= 1'b0;
        of_out <= 1'b0;
        sf_out <= div_r[BYTE_W-1];
        zf_out <= (div_r == '0);
        pf_out <= ~^div_r;
      end
    end
  end
endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [2:0]  op,
  input logic [7:0]  al_in,
  input logic [7:0]  ah_in,
  input logic [15:0] dx_in,
  input logic        af_in,
  input logic        cf_in,
  input logic        busy,
  input logic        done,
  input logic [7:0]  al_out,
  input logic [7:0]  ah_out,
  input logic [15:0] dx_out,
  input logic        cf_out,
  input logic        pf_out,
  input logic        af_out,
  input logic        zf_out,
  input logic        sf_out,
  input logic        of_out
);
  logic [2:0] op_q;
  logic [3:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= 3'd0;
      wait_cnt <= 4'd0;
    end else begin
      if (start && !busy) op_q <= op;
      if (!busy) wait_cnt <= 4'd0;
      else if (wait_cnt != 4'hF) wait_cnt <= wait_cnt + 4'd1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && !done && al_out == 8'h00));

  p_unpacked_fix_r2: assert property (@(posedge clk) disable iff (rst)
    (done && op_q inside {3'd0, 3'd1}) |-> (al_out[7:4] == 4'h0 && af_out == cf_out));

  p_split_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 3'd4) |=> (busy && !done));

  p_split_digit_r6: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == 3'd4) |-> (al_out < 8'd10 && ah_out < 8'd26));

  p_split_bound_r6: assert property (@(posedge clk) disable iff (rst) wait_cnt < 4'd12);

  p_merge_high_r7: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == 3'd5) |-> (ah_out == 8'h00));

  p_widen_byte_r8: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == 3'd6) |-> (ah_out == {8{al_out[7]}}));

  p_widen_word_r9: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == 3'd7) |-> (dx_out == {16{ah_out[7]}}));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(al_out) && $stable(ah_out) && $stable(dx_out)));

  p_no_done_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !done);

  p_flags_r11: assert property (@(posedge clk) disable iff (rst)
    (done && op_q inside {3'd2, 3'd3, 3'd4, 3'd5}) |-> (pf_out == ~^al_out && sf_out == al_out[7] && !of_out));
endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk u_chk (.*);

// File: tb/bcd_adjust_unit_test.sv
module bcd_adjust_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [7:0]  al_in = 8'h00, ah_in = 8'h00;
  logic [15:0] dx_in = 16'h0000;
  logic        af_in = 1'b0, cf_in = 1'b0;
  logic        busy, done;
  logic [7:0]  al_out, ah_out;
  logic [15:0] dx_out;
  logic        cf_out, pf_out, af_out, zf_out, sf_out, of_out;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [15:0] ext;
    logic cf, pf, af, zf, sf, of;
  } exp_t;

  always #2.5 clk = ~clk;

  bcd_adjust_unit uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .al_in(al_in), .ah_in(ah_in),
    .dx_in(dx_in), .af_in(af_in), .cf_in(cf_in), .busy(busy), .done(done),
    .al_out(al_out), .ah_out(ah_out), .dx_out(dx_out), .cf_out(cf_out),
    .pf_out(pf_out), .af_out(af_out), .zf_out(zf_out), .sf_out(sf_out), .of_out(of_out)
  );

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(input logic [2:0] o, input logic [7:0] a, input logic [7:0] h,
                                 input logic [15:0] d, input logic fa, input logic fc);
    exp_t e;
    int   v;
    e = '0; e.lo = a; e.hi = h; e.ext = d;
    case (o)
      3'd0, 3'd1: begin
        if (a[3:0] > 4'd9 || fa) begin
          v    = (o == 3'd0) ? int'(a) + 6 : int'(a) - 6;
          e.lo = 8'(v & 15);
          e.hi = (o == 3'd0) ? h + 8'd1 : h - 8'd1;
          e.af = 1'b1; e.cf = 1'b1;
        end else e.lo = a & 8'h0F;
      end
      3'd2, 3'd3: begin
        v = int'(a);
        if (a[3:0] > 4'd9 || fa) begin v = (o == 3'd2) ? v + 6 : v - 6; e.af = 1'b1; end
        if (a > 8'h99 || fc) begin v = (o == 3'd2) ? v + 96 : v - 96; e.cf = 1'b1; end
        e.lo = 8'(v);
      end
      3'd4: begin e.hi = 8'(a / 10); e.lo = 8'(a % 10); end
      3'd5: begin e.lo = 8'(int'(h) * 10 + int'(a)); e.hi = 8'h00; end
      3'd6: begin e.hi = a[7] ? 8'hFF : 8'h00; e.af = fa; e.cf = fc; end
      default: begin e.ext = h[7] ? 16'hFFFF : 16'h0000; e.af = fa; e.cf = fc; end
    endcase
    if (o inside {3'd2, 3'd3, 3'd4, 3'd5}) begin
      e.sf = e.lo[7];
      e.zf = (e.lo == 8'h00);
      e.pf = ($countones(e.lo) % 2) == 0;
    end
    return e;
  endfunction

  function automatic exp_t actual();
    return {al_out, ah_out, dx_out, cf_out, pf_out, af_out, zf_out, sf_out, of_out};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [7:0] a, input logic [7:0] h,
                        input logic [15:0] d, input logic fa, input logic fc, input bit poke);
    exp_t e;
    int   n;
    e = model(o, a, h, d, fa, fc);
    @(negedge clk);
    op = o; al_in = a; ah_in = h; dx_in = d; af_in = fa; cf_in = fc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op = 3'($urandom); al_in = 8'($urandom); ah_in = 8'($urandom); dx_in = 16'($urandom);
    n = 1;
    if (o == 3'd4) begin
      check(busy && !done, "R6", "busy after split start", {38'd0, busy, done}, 40'd2);
      if (poke) begin
        op = 3'd6; al_in = 8'h80; ah_in = 8'h11; start = 1'b1;
        @(negedge clk);
        start = 1'b0; n++;
        check(!done, "R10", "start during busy produced done", {39'd0, done}, 40'd0);
      end
      while (!done && n < 30) begin @(negedge clk); n++; end
      check(n <= 12, "R6", "split latency", 40'(n), 40'd12);
    end
    check(done == 1'b1, tag(o), "done pulse", {39'd0, done}, 40'd1);
    check(actual() == e, tag(o), "result", actual(), e);
    if (o == 3'd7) check(dx_out == e.ext, "R9", "word widen", 40'(dx_out), 40'(e.ext));
    else check(dx_out == d, "R10", "extension word passes", 40'(dx_out), 40'(d));
    check(!of_out && (o > 3'd1 || (!sf_out && !zf_out && !pf_out)), "R11", "undefined flags zero",
          {34'd0, sf_out, zf_out, pf_out, of_out, 2'd0}, 40'd0);
    @(negedge clk);
    check(!done, "R10", "done lasts one cycle", {39'd0, done}, 40'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !done && al_out == 0 && ah_out == 0 && dx_out == 0, "R1", "reset outputs",
          {al_out, ah_out, dx_out, 6'd0, busy, done}, 40'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && {cf_out, pf_out, af_out, zf_out, sf_out, of_out} == 0, "R1", "after reset",
          {32'd0, cf_out, pf_out, af_out, zf_out, sf_out, of_out, busy, done}, 40'd0);

    run_op(3'd0, 8'h66, 8'h00, 16'h1234, 1'b0, 1'b0, 0); // R2 ascii 2+4
    run_op(3'd0, 8'h3A, 8'h05, 16'h0000, 1'b0, 1'b0, 0); // R2 low nibble above 9
    run_op(3'd0, 8'h31, 8'hFF, 16'h0000, 1'b1, 1'b0, 0); // R2 af forces, ah wraps
    run_op(3'd1, 8'hFF, 8'h00, 16'h0000, 1'b1, 1'b0, 0); // R3 borrow into ah
    run_op(3'd1, 8'h39, 8'h02, 16'h0000, 1'b0, 1'b1, 0); // R3 no fix
    run_op(3'd2, 8'h9A, 8'h00, 16'h0000, 1'b0, 1'b0, 0); // R4 both fixes to zero
    run_op(3'd2, 8'h99, 8'h00, 16'h0000, 1'b0, 1'b0, 0); // R4 boundary, no fix
    run_op(3'd2, 8'h12, 8'h00, 16'h0000, 1'b1, 1'b1, 0); // R4 flags force
    run_op(3'd3, 8'h0F, 8'h00, 16'h0000, 1'b0, 1'b0, 0); // R5
    run_op(3'd3, 8'hA0, 8'h00, 16'h0000, 1'b0, 1'b0, 0); // R5 high fix
    run_op(3'd4, 8'hFF, 8'h00, 16'hBEEF, 1'b1, 1'b1, 0); // R6 split max
    run_op(3'd4, 8'h00, 8'h77, 16'h0000, 1'b0, 1'b0, 0); // R6 zero
    run_op(3'd4, 8'h5B, 8'h00, 16'hCAFE, 1'b0, 1'b0, 1); // R10 start during busy ignored
    run_op(3'd5, 8'h09, 8'h09, 16'h0000, 1'b1, 1'b1, 0); // R7 99
    run_op(3'd5, 8'hFF, 8'hFF, 16'h0000, 1'b0, 1'b0, 0); // R7 wrap
    run_op(3'd6, 8'h80, 8'h12, 16'h0000, 1'b1, 1'b0, 0); // R8 negative
    run_op(3'd6, 8'h7F, 8'hFF, 16'h0000, 1'b0, 1'b1, 0); // R8 positive
    run_op(3'd7, 8'h00, 8'h80, 16'h1234, 1'b0, 1'b0, 0); // R9 negative
    run_op(3'd7, 8'hFF, 8'h7F, 16'hFFFF, 1'b1, 1'b1, 0); // R9 positive

    for (int i = 0; i < 400; i++) begin
      run_op(3'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
             1'($urandom), 1'($urandom), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule